// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Bus Master

This block sits between an internal requester and an external device that shares one 32-bit set of lines for both address and data. Each accepted request becomes one bus transfer: a single address cycle, in which the byte address and an access-size code go out together on the shared lines, followed by one data beat for byte, halfword and word accesses, or four data beats for a 16-byte burst. A read always inserts one idle turnaround cycle between the address cycle and the first data cycle, so the external device can take over the lines. This happens even when no software waits are programmed.

Each data beat can be lengthened in two ways. A static count of software waits (`cfg_sw_waits`) sets a minimum beat length. An active-low hold input from the device stretches the beat further for as long as it stays low. The internal side takes a request with a valid/ready handshake. It reports each write beat the bus has taken, delivers each read word with a one-cycle valid pulse, and signals the end of a transfer with a completion pulse.

Top module: `mpx_burst_master`

## Requirements
- R1: While idle, `req_ready` is 1, `bus_sel_n`, `bus_burst_n` and `bus_start_n` are 1, and `bus_ad_oe` is 0.
- R2: The cycle after a request is accepted is the address cycle, which lasts exactly one cycle. In it, `bus_start_n`, `bus_sel_n` and `bus_burst_n` are 0 and `bus_ad_oe` is 1. The shared lines carry the byte address on bits 25..0, zeros on bits 28..26 and the size code on bits 31..29. The size codes are 000 byte, 001 halfword, 010 word and 011 16-byte burst. `bus_rd` is 1 for a read and 0 for a write.
- R3: A read transfer has exactly one turnaround cycle after the address cycle, even with `cfg_sw_waits` = 0. In that cycle `bus_sel_n` and `bus_burst_n` stay 0. `bus_ad_oe` is 0 from the turnaround cycle through the end of the read.
- R4: A data beat that starts with `cfg_sw_waits` = S, while `bus_hold_n` is held low for the first H cycles of the beat, completes in its cycle number max(S,H), counting from 0. A beat never completes in a cycle where `bus_hold_n` is 0.
- R5: The word on `bus_ad_i` is captured at the clock edge that ends a read beat. It appears on `rd_data` with `rd_valid` = 1 for exactly the following cycle.
- R6: During every cycle of a write beat, `bus_ad_oe` is 1 and `bus_ad_o` equals `req_wdata`. `wdata_ack` is 1 only in the cycle in which the beat completes.
- R7: `bus_sel_n` is 0 for the whole transfer, including every wait cycle. `bus_burst_n` is 0 from the address cycle through every beat except the final one, and is 1 throughout the final beat.
- R8: Size code 011 produces four data beats. The codes 000, 001 and 010 produce one beat.
- R9: A request whose size code has bit 2 set (reserved) is accepted but causes no bus activity. `done` pulses in the cycle after acceptance.
- R10: `done` is 1 for exactly the one cycle after the last beat completes. In that cycle the block is already idle, with `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sw_waits | input | WAIT_W | Minimum number of extra cycles per data beat |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access-size code (see R2, R9) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write word for the current beat |
| wdata_ack | output | 1 | Current write beat completes this cycle |
| rd_valid | output | 1 | `rd_data` holds a read word |
| rd_data | output | DATA_W | Captured read word |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| bus_sel_n | output | 1 | Device select, active low |
| bus_burst_n | output | 1 | Transfer-in-progress strobe, active low |
| bus_rd | output | 1 | Direction, 1 = read |
| bus_start_n | output | 1 | Address-cycle strobe, active low |
| bus_hold_n | input | 1 | Device hold request, active low |
| bus_ad_o | output | DATA_W | Shared-line output value |
| bus_ad_oe | output | 1 | Shared-line output enable |
| bus_ad_i | input | DATA_W | Shared-line input value |

## Verification
Every cycle, the assertions check these rules:
- The start strobe lasts one cycle, and the address cycle drives the lines with a zero pad and a legal size code.
- A read has its turnaround cycle and never drives the lines during its data phase.
- No beat completes while the hold input is low.
- The select line covers the burst strobe, and idle outputs are quiet.

Only the bench scenarios can show the rest:
- exact beat lengths for different mixes of software and hardware waits,
- the address and size values,
- the point where the burst strobe rises on the final beat,
- the beat count of a burst,
- the correct read and write words, in order,
- the silent completion of a reserved-size request.

// File: rtl/mpx_pkg.sv
package mpx_pkg;

   localparam int MPX_SIZE_W = 3;

   typedef enum logic [MPX_SIZE_W-1:0] {
      SZ_BYTE  = 3'b000,
      SZ_HALF  = 3'b001,
      SZ_WORD  = 3'b010,
      SZ_BURST = 3'b011
   } mpx_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_TURN = 2'd2,
      ST_DATA = 2'd3
   } mpx_state_e;

   typedef struct packed {
      logic                  wr;
      logic [MPX_SIZE_W-1:0] size;
   } mpx_cmd_t;

   function automatic logic size_legal(input logic [MPX_SIZE_W-1:0] code);
      return !code[MPX_SIZE_W-1];
   endfunction

   function automatic logic size_is_burst(input logic [MPX_SIZE_W-1:0] code);
      return code == SZ_BURST;
   endfunction

endpackage

// File: rtl/mpx_wait_timer.sv
module mpx_wait_timer #(
   parameter int WAIT_W = 4,
   parameter bit EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   output logic              expired
);

   if (WAIT_W < 1) begin : g_bad_w
      $error("mpx_wait_timer: WAIT_W must be at least 1");
   end

   if (EN) begin : g_cnt
      logic [WAIT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= load_val;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign expired = (cnt_q == '0);
   end else begin : g_none
      logic unused_tie;
      assign unused_tie = ^{clk, rst_n, load, load_val};
      assign expired    = 1'b1;
   end

endmodule

// File: rtl/mpx_beat_counter.sv
module mpx_beat_counter #(
   parameter int BURST_BEATS = 4,
   localparam int BEAT_W     = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_burst,
   input  logic step,
   output logic last
);

   localparam logic [BEAT_W-1:0] BURST_LAST = BEAT_W'(BURST_BEATS - 1);

   logic [BEAT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= load_burst ? BURST_LAST : '0;
      end else if (step && left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign last = (left_q == '0);

endmodule

// File: rtl/mpx_ad_mux.sv
module mpx_ad_mux #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 26,
   parameter int SIZE_W = 3,
   localparam int PAD_W = DATA_W - SIZE_W - ADDR_W
) (
   input  logic              addr_phase,
   input  logic              wr_phase,
   input  logic [SIZE_W-1:0] size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe
);

   logic [DATA_W-1:0] addr_word;

   if (PAD_W > 0) begin : g_pad
      assign addr_word = {size, {PAD_W{1'b0}}, addr};
   end else begin : g_nopad
      assign addr_word = {size, addr};
   end

   always_comb begin
      ad_o = wdata;
      if (addr_phase) begin
         ad_o = addr_word;
      end
   end

   assign ad_oe = addr_phase | wr_phase;

endmodule

// File: rtl/mpx_burst_master.sv
module mpx_burst_master
   import mpx_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter int DATA_W      = 32,
   parameter int WAIT_W      = 4,
   parameter int BURST_BEATS = 4,
   parameter bit SW_WAIT_EN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [WAIT_W-1:0]     cfg_sw_waits,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [MPX_SIZE_W-1:0] req_size,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  wdata_ack,
   output logic                  rd_valid,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  done,
   output logic                  bus_sel_n,
   output logic                  bus_burst_n,
   output logic                  bus_rd,
   output logic                  bus_start_n,
   input  logic                  bus_hold_n,
   output logic [DATA_W-1:0]     bus_ad_o,
   output logic                  bus_ad_oe,
   input  logic [DATA_W-1:0]     bus_ad_i
);

   localparam int PAD_W = DATA_W - MPX_SIZE_W - ADDR_W;

   if (DATA_W != 32) begin : g_bad_data
      $error("mpx_burst_master: the shared bus is fixed at 32 bits");
   end
   if (PAD_W < 0) begin : g_bad_addr
      $error("mpx_burst_master: address and size do not fit the shared bus");
   end
   if (BURST_BEATS < 2) begin : g_bad_beats
      $error("mpx_burst_master: BURST_BEATS must be at least 2");
   end

   mpx_state_e        st_q, st_d;
   mpx_cmd_t          cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept, accept_ok, accept_bad;
   logic              in_addr, in_turn, in_data, active;
   logic              wait_done, beat_last, beat_done;
   logic              timer_load;

   assign accept     = req_valid && (st_q == ST_IDLE);
   assign accept_ok  = accept && size_legal(req_size);
   assign accept_bad = accept && !size_legal(req_size);

   assign in_addr = (st_q == ST_ADDR);
   assign in_turn = (st_q == ST_TURN);
   assign in_data = (st_q == ST_DATA);
   assign active  = (st_q != ST_IDLE);

   assign beat_done = in_data && wait_done && bus_hold_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         addr_q <= '0;
      end else if (accept_ok) begin
         cmd_q.wr   <= req_write;
         cmd_q.size <= req_size;
         addr_q     <= req_addr;
      end
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept_ok) st_d = ST_ADDR;
         ST_ADDR: st_d = cmd_q.wr ? ST_DATA : ST_TURN;
         ST_TURN: st_d = ST_DATA;
         ST_DATA: if (beat_done && beat_last) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign timer_load = (in_addr && cmd_q.wr) || in_turn || (beat_done && !beat_last);

   mpx_wait_timer #(
      .WAIT_W (WAIT_W),
      .EN     (SW_WAIT_EN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (cfg_sw_waits),
      .expired  (wait_done)
   );

   mpx_beat_counter #(
      .BURST_BEATS (BURST_BEATS)
   ) u_beats (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept_ok),
      .load_burst (size_is_burst(req_size)),
      .step       (beat_done),
      .last       (beat_last)
   );

   mpx_ad_mux #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .SIZE_W (MPX_SIZE_W)
   ) u_mux (
      .addr_phase (in_addr),
      .wr_phase   (in_data && cmd_q.wr),
      .size       (cmd_q.size),
      .addr       (addr_q),
      .wdata      (req_wdata),
      .ad_o       (bus_ad_o),
      .ad_oe      (bus_ad_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
      end else begin
         rd_valid <= beat_done && !cmd_q.wr;
         if (beat_done && !cmd_q.wr) begin
            rd_data <= bus_ad_i;
         end
         done <= (beat_done && beat_last) || accept_bad;
      end
   end

   assign req_ready   = (st_q == ST_IDLE);
   assign wdata_ack   = beat_done && cmd_q.wr;
   assign bus_sel_n   = !active;
   assign bus_start_n = !in_addr;
   assign bus_burst_n = !(in_addr || in_turn || (in_data && !beat_last));
   assign bus_rd      = active ? !cmd_q.wr : 1'b1;

endmodule

// File: rtl/mpx_burst_master_chk.sv
module mpx_burst_master_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              wdata_ack,
   input logic              rd_valid,
   input logic              done,
   input logic              bus_sel_n,
   input logic              bus_burst_n,
   input logic              bus_rd,
   input logic              bus_start_n,
   input logic              bus_hold_n,
   input logic [DATA_W-1:0] bus_ad_o,
   input logic              bus_ad_oe
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_sel_n && bus_start_n && bus_burst_n && !bus_ad_oe)); // R1

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_start_n |=> bus_start_n); // R2

   AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_start_n |-> (bus_ad_oe && !bus_sel_n && !bus_burst_n && bus_ad_o[28:26] == 3'b000)); // R2

   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_start_n |-> !bus_ad_o[31]); // R9

   AST_READ_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_start_n && bus_rd) |=> (!bus_ad_oe && !bus_sel_n && !bus_burst_n && bus_start_n)); // R3

   AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel_n && bus_rd && bus_start_n) |-> !bus_ad_oe); // R3

   AST_HOLD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_ack |-> bus_hold_n); // R4

   AST_HOLD_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bus_hold_n)); // R4

   AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_ack |-> (bus_ad_oe && !bus_rd && !bus_sel_n)); // R6

   AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_burst_n |-> !bus_sel_n); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && bus_sel_n)); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

endmodule

bind mpx_burst_master mpx_burst_master_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mpx_burst_master_bench.sv
module mpx_burst_master_bench;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   typedef struct {
      bit          wr;
      logic [2:0]  size;
      logic [25:0] addr;
      logic [31:0] base;
   } txn_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_sw_waits = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [2:0]  req_size = '0;
   logic [25:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        wdata_ack, rd_valid, done;
   logic [31:0] rd_data;
   logic        bus_sel_n, bus_burst_n, bus_rd, bus_start_n;
   logic        bus_hold_n = 1'b1;
   logic [31:0] bus_ad_o;
   logic        bus_ad_oe;
   logic [31:0] bus_ad_i = '0;

   mpx_burst_master u_mpx_burst_master (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_sw_waits (cfg_sw_waits),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_size     (req_size),
      .req_addr     (req_addr),
      .req_wdata    (req_wdata),
      .wdata_ack    (wdata_ack),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .done         (done),
      .bus_sel_n    (bus_sel_n),
      .bus_burst_n  (bus_burst_n),
      .bus_rd       (bus_rd),
      .bus_start_n  (bus_start_n),
      .bus_hold_n   (bus_hold_n),
      .bus_ad_o     (bus_ad_o),
      .bus_ad_oe    (bus_ad_oe),
      .bus_ad_i     (bus_ad_i)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   int sw = 0;
   int hw = 0;
   int cycles = 0;

   txn_t        txn_q[$];
   logic [31:0] rd_q[$];
   txn_t        cur;
   bit          in_x = 0, turn = 0, rd_due = 0, done_due = 0;
   int          beat = 0, cyc = 0, nb = 0, tgt = 0, last_nb = 0, dut_beats = 0;
   bit          nxt_hold = 1'b1;
   logic [31:0] nxt_ad = '0;

   function automatic logic [31:0] wd(input logic [31:0] base, input int b);
      return base + 32'h1111_1111 * b;
   endfunction

   function automatic logic [31:0] rdf(input logic [25:0] a, input int b);
      return 32'hA500_0000 ^ {6'b0, a} ^ (32'h0101_0101 * b);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   // hold and read data are applied a quarter cycle after the rising edge
   always @(posedge clk) begin
      #(CLK_PERIOD / 4);
      bus_hold_n = nxt_hold;
      bus_ad_i   = nxt_ad;
   end

   // slave model and scoreboard monitor
   always @(negedge clk) begin
      bit nd;
      int nc;
      bit lastb;
      if (rst_n) begin
         dut_beats += int'(wdata_ack) + int'(rd_valid);
         chk(rd_valid == rd_due, "R5 rd_valid timing", 32'(rd_valid), 32'(rd_due));
         if (rd_valid && rd_due && rd_q.size() > 0) begin
            logic [31:0] e;
            e = rd_q.pop_front();
            chk(rd_data == e, "R5 read word", rd_data, e);
         end
         chk(done == done_due, "R10 done timing", 32'(done), 32'(done_due));
         if (done_due) begin
            chk(req_ready, "R10 idle at done", 32'(req_ready), 32'd1);
            chk(dut_beats == last_nb, "R8 beat count", 32'(dut_beats), 32'(last_nb));
            dut_beats = 0;
         end
         rd_due   = 0;
         done_due = 0;
         nd       = 0;
         nc       = 0;
         if (!bus_start_n) begin
            if (txn_q.size() == 0) begin
               chk(0, "R9 unexpected address cycle", bus_ad_o, 32'h0);
            end else begin
               cur = txn_q.pop_front();
               chk(bus_ad_o[25:0] == cur.addr, "R2 address field", 32'(bus_ad_o[25:0]), 32'(cur.addr));
               chk(bus_ad_o[31:29] == cur.size, "R2 size field", 32'(bus_ad_o[31:29]), 32'(cur.size));
               chk(bus_ad_o[28:26] == 3'b000, "R2 pad field", 32'(bus_ad_o[28:26]), 32'h0);
               chk(bus_ad_oe && !bus_sel_n && !bus_burst_n, "R2 address strobes",
                   {29'b0, bus_ad_oe, bus_sel_n, bus_burst_n}, 32'h4);
               chk(bus_rd == !cur.wr, "R2 direction", 32'(bus_rd), 32'(!cur.wr));
               in_x    = 1;
               beat    = 0;
               cyc     = 0;
               turn    = !cur.wr;
               nb      = (cur.size == 3'b011) ? 4 : 1;
               last_nb = nb;
               tgt     = (sw > hw) ? sw : hw;
               if (cur.wr) nd = 1;
            end
         end else if (in_x) begin
            chk(!bus_sel_n, "R7 select held", 32'(bus_sel_n), 32'h0);
            if (turn) begin
               chk(!bus_ad_oe, "R3 turnaround undriven", 32'(bus_ad_oe), 32'h0);
               chk(!bus_burst_n, "R3 turnaround strobe", 32'(bus_burst_n), 32'h0);
               turn = 0;
               nd   = 1;
            end else begin
               lastb = (beat == nb - 1);
               chk(bus_burst_n == lastb, (nb > 1) ? "R8 burst strobe" : "R7 strobe on final beat",
                   32'(bus_burst_n), 32'(lastb));
               if (cur.wr) begin
                  chk(bus_ad_oe, "R6 write driven", 32'(bus_ad_oe), 32'h1);
                  chk(wdata_ack == (cyc == tgt), "R4 write beat length", 32'(wdata_ack), 32'(cyc == tgt));
               end else begin
                  chk(!bus_ad_oe, "R3 read undriven", 32'(bus_ad_oe), 32'h0);
               end
               if (cyc == tgt) begin
                  if (cur.wr) begin
                     chk(bus_ad_o == wd(cur.base, beat), "R6 write word", bus_ad_o, wd(cur.base, beat));
                  end else begin
                     rd_q.push_back(rdf(cur.addr, beat));
                     rd_due = 1;
                  end
                  if (lastb) begin
                     in_x     = 0;
                     done_due = 1;
                  end else begin
                     beat++;
                     cyc = 0;
                     nd  = 1;
                  end
               end else begin
                  cyc++;
                  nd = 1;
                  nc = cyc;
               end
            end
         end else begin
            chk(bus_sel_n && !bus_ad_oe, "R1 idle bus", {30'b0, bus_sel_n, bus_ad_oe}, 32'h2);
         end
         nxt_hold = !(nd && nc < hw);
         nxt_ad   = rdf(cur.addr, beat);
      end
   end

   task automatic xfer(input bit w, input logic [2:0] sz, input logic [25:0] a, input logic [31:0] base);
      txn_t t;
      int   k;
      bit   seen_ack, seen_done;
      t.wr = w; t.size = sz; t.addr = a; t.base = base;
      if (!sz[2]) txn_q.push_back(t);
      else last_nb = 0;
      req_valid = 1'b1;
      req_write = w;
      req_size  = sz;
      req_addr  = a;
      req_wdata = wd(base, 0);
      @(posedge clk);
      #(CLK_PERIOD / 4);
      req_valid = 1'b0;
      if (sz[2]) begin
         done_due = 1;   // R9: completion without bus traffic
         @(posedge clk);
         #(CLK_PERIOD / 4);
      end else begin
         k = 0;
         seen_done = 0;
         while (!seen_done) begin
            @(negedge clk);
            seen_ack  = wdata_ack;
            seen_done = done;
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (seen_ack) begin
               k++;
               req_wdata = wd(base, k);
            end
         end
      end
   endtask

   task automatic set_waits(input int s, input int h);
      sw = s;
      hw = h;
      cfg_sw_waits = 4'(s);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_PERIOD / 4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(req_ready && bus_sel_n && bus_burst_n && bus_start_n && !bus_ad_oe && !done && !rd_valid,
          "R1 reset state",
          {25'b0, req_ready, bus_sel_n, bus_burst_n, bus_start_n, bus_ad_oe, done, rd_valid}, 32'h78);
      @(posedge clk);
      #(CLK_PERIOD / 4);

      set_waits(0, 0);
      xfer(1'b1, 3'b010, 26'h012_3456, 32'hCAFE_0001);   // R2 R6 word write, no waits
      xfer(1'b0, 3'b010, 26'h3FF_FFFC, 32'h0);           // R3 R5 read, auto turnaround
      set_waits(2, 0);
      xfer(1'b0, 3'b001, 26'h000_0102, 32'h0);           // R4 software waits, halfword read
      set_waits(0, 3);
      xfer(1'b1, 3'b011, 26'h1AB_CDE0, 32'h1000_0000);   // R4 R8 burst write with hold
      set_waits(1, 2);
      xfer(1'b0, 3'b011, 26'h200_0010, 32'h0);           // R8 R5 burst read, mixed waits
      set_waits(3, 1);
      xfer(1'b1, 3'b000, 26'h000_0007, 32'h0000_00A5);   // R2 byte write
      set_waits(0, 0);
      xfer(1'b1, 3'b101, 26'h155_5555, 32'h0);           // R9 reserved code
      xfer(1'b0, 3'b111, 26'h2AA_AAAA, 32'h0);           // R9 reserved code, read
      xfer(1'b0, 3'b011, 26'h0F0_F0F0, 32'h0);           // R7 burst read, no waits
      set_waits(4, 4);
      xfer(1'b1, 3'b011, 26'h321_0000, 32'h7700_0000);   // R4 equal soft and hard waits

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(txn_q.size() == 0, "R2 transfers outstanding", 32'(txn_q.size()), 32'h0);
      chk(rd_q.size() == 0, "R5 reads outstanding", 32'(rd_q.size()), 32'h0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule